// File: doc/BRIEF.md
# Configurable Binary/Ternary Row Matcher

This block takes one row word fetched from a hashed lookup table and compares a search key against every entry packed in that row, all in parallel. Each key bit position can be treated as binary (stored value must equal the key bit) or ternary (the entry may mark the bit as don't-care). A per-position mode mask chooses between the two, so one key can mix exact fields and wildcard fields.

The row is built from fixed narrow slots. In narrow mode each slot is one entry. In wide mode two neighbouring slots join into one entry of twice the key width, so the same comparator array serves two key sizes. The key is fanned out to every slot, each slot produces a per-slot match, the slot matches are merged into entry matches for the selected width, and the lowest-numbered matching entry wins. Its index and its stored result data are returned. If entries are written longest-prefix first, this priority gives longest-prefix-match lookups. The outputs pass through one register stage by default, or appear in the same cycle when `REG_OUT` is 0.

Top module: `row_match_engine`

## Requirements
- R1: Within a compared slot, key bit b matches when `mode_mask[b]` is 1 and the slot's don't-care bit b is 1. Otherwise the stored value bit must equal the key bit. A don't-care bit at a position whose mode bit is 0 has no effect.
- R2: Slot i takes row bits `[i*SLOT_W +: SLOT_W]`, with SLOT_W = 2*KEY_W + DATA_W, laid out as value (low KEY_W bits), don't-care (next KEY_W bits) and data (top DATA_W bits). In narrow mode (`wide_sel`=0) slot i is entry i, compared against `key[KEY_W-1:0]` and `mode_mask[KEY_W-1:0]`, and `match_vec[i]` gives its result.
- R3: In wide mode (`wide_sel`=1), entry j is made of slot 2j, compared against the low key half, and slot 2j+1, compared against the high key half. It matches only when both slots match. `match_vec` bits j at or above SLOTS/2 are always 0.
- R4: `hit` is 1 exactly when any bit of `match_vec` is 1.
- R5: On a hit, `idx` is the lowest set position of `match_vec`.
- R6: On a hit, narrow mode returns the winning slot's data zero-extended in `data`. Wide mode returns {data of slot 2j+1, data of slot 2j}.
- R7: With no match, `hit`, `idx` and `data` are all 0.
- R8: With `REG_OUT`=1, all outputs appear one clock after the inputs and `out_valid` follows `in_valid` by one clock. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Inputs carry a lookup this cycle |
| wide_sel | input | 1 | 0: narrow entries, 1: double-width entries |
| row | input | SLOTS*(2*KEY_W+DATA_W) | Fetched row word |
| key | input | 2*KEY_W | Search key (narrow mode uses low half) |
| mode_mask | input | 2*KEY_W | Per bit position: 1 ternary, 0 binary |
| out_valid | output | 1 | Outputs carry a lookup result |
| match_vec | output | SLOTS | Per-entry match flags |
| hit | output | 1 | Any entry matched |
| idx | output | clog2(SLOTS) | Index of winning entry |
| data | output | 2*DATA_W | Result data of winning entry |

## Verification
The assertions assume that `wide_sel` and `in_valid` are known in every cycle after reset. They also assume that a result is only read while `out_valid` is high. The bench drives every input on the falling edge and changes `wide_sel` only together with a new row. Random rows plant key copies into about a third of the slots, with random don't-care bits on ternary positions, so hits, misses and multi-hit priority all occur in both widths.

// File: rtl/rme_pkg.sv
package rme_pkg;
   typedef enum logic {WIDTH_NARROW = 1'b0, WIDTH_WIDE = 1'b1} width_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rme_key_fanout.sv
module rme_key_fanout #(
   parameter int SLOTS = 8,
   parameter int KEY_W = 16
) (
   input  rme_pkg::width_e          width,
   input  logic [2*KEY_W-1:0]       key,
   input  logic [2*KEY_W-1:0]       mode_mask,
   output logic [SLOTS*KEY_W-1:0]   lane_key,
   output logic [SLOTS*KEY_W-1:0]   lane_mode
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_lane
      if (i % 2 == 1) begin : g_odd
         always_comb begin
            if (width == rme_pkg::WIDTH_WIDE) begin
               lane_key[i*KEY_W +: KEY_W]  = key[KEY_W +: KEY_W];
               lane_mode[i*KEY_W +: KEY_W] = mode_mask[KEY_W +: KEY_W];
            end else begin
               lane_key[i*KEY_W +: KEY_W]  = key[KEY_W-1:0];
               lane_mode[i*KEY_W +: KEY_W] = mode_mask[KEY_W-1:0];
            end
         end
      end else begin : g_even
         assign lane_key[i*KEY_W +: KEY_W]  = key[KEY_W-1:0];
         assign lane_mode[i*KEY_W +: KEY_W] = mode_mask[KEY_W-1:0];
      end
   end
endmodule

// File: rtl/rme_slot_cmp.sv
module rme_slot_cmp #(
   parameter int SLOTS  = 8,
   parameter int KEY_W  = 16,
   parameter int DATA_W = 8,
   localparam int SLOT_W = 2*KEY_W + DATA_W
) (
   input  logic [SLOTS*SLOT_W-1:0]  row,
   input  logic [SLOTS*KEY_W-1:0]   lane_key,
   input  logic [SLOTS*KEY_W-1:0]   lane_mode,
   output logic [SLOTS-1:0]         slot_hit
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [KEY_W-1:0] val, dc, bit_ok;
      assign val    = row[i*SLOT_W +: KEY_W];
      assign dc     = row[i*SLOT_W + KEY_W +: KEY_W];
      assign bit_ok = ~(val ^ lane_key[i*KEY_W +: KEY_W])
                    | (lane_mode[i*KEY_W +: KEY_W] & dc);
      assign slot_hit[i] = &bit_ok;
   end
endmodule

// File: rtl/rme_entry_merge.sv
module rme_entry_merge #(
   parameter int SLOTS = 8,
   localparam int WIDE_N = SLOTS / 2
) (
   input  rme_pkg::width_e   width,
   input  logic [SLOTS-1:0]  slot_hit,
   output logic [SLOTS-1:0]  ent_match
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_ent
      logic wide_v;
      if (i < WIDE_N) begin : g_pair
         assign wide_v = slot_hit[2*i] & slot_hit[2*i+1];
      end else begin : g_unused
         assign wide_v = 1'b0;
      end
      assign ent_match[i] = (width == rme_pkg::WIDTH_WIDE) ? wide_v : slot_hit[i];
   end
endmodule

// File: rtl/rme_prio_extract.sv
module rme_prio_extract #(
   parameter int SLOTS  = 8,
   parameter int KEY_W  = 16,
   parameter int DATA_W = 8,
   localparam int SLOT_W = 2*KEY_W + DATA_W,
   localparam int WIDE_N = SLOTS / 2,
   localparam int IDX_W  = rme_pkg::idx_bits(SLOTS)
) (
   input  rme_pkg::width_e           width,
   input  logic [SLOTS*SLOT_W-1:0]   row,
   input  logic [SLOTS-1:0]          ent_match,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx,
   output logic [2*DATA_W-1:0]       data
);
   logic [2*DATA_W-1:0] cand [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_cand
      logic [DATA_W-1:0] own_d;
      assign own_d = row[i*SLOT_W + 2*KEY_W +: DATA_W];
      if (i < WIDE_N) begin : g_wide
         logic [DATA_W-1:0] lo_d, hi_d;
         assign lo_d = row[(2*i)*SLOT_W + 2*KEY_W +: DATA_W];
         assign hi_d = row[(2*i+1)*SLOT_W + 2*KEY_W +: DATA_W];
         assign cand[i] = (width == rme_pkg::WIDTH_WIDE) ? {hi_d, lo_d}
                                                         : {{DATA_W{1'b0}}, own_d};
      end else begin : g_narrow
         assign cand[i] = (width == rme_pkg::WIDTH_WIDE) ? '0
                                                         : {{DATA_W{1'b0}}, own_d};
      end
   end

   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      data = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (ent_match[i]) begin
            hit  = 1'b1;
            idx  = IDX_W'(i);
            data = cand[i];
         end
      end
   end
endmodule

// File: rtl/row_match_engine.sv
module row_match_engine #(
   parameter int SLOTS   = 8,
   parameter int KEY_W   = 16,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int SLOT_W = 2*KEY_W + DATA_W,
   localparam int ROW_W  = SLOTS * SLOT_W,
   localparam int IDX_W  = rme_pkg::idx_bits(SLOTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  wide_sel,
   input  logic [ROW_W-1:0]      row,
   input  logic [2*KEY_W-1:0]    key,
   input  logic [2*KEY_W-1:0]    mode_mask,
   output logic                  out_valid,
   output logic [SLOTS-1:0]      match_vec,
   output logic                  hit,
   output logic [IDX_W-1:0]      idx,
   output logic [2*DATA_W-1:0]   data
);
   if (SLOTS < 2)  begin : g_bad_slots  $error("SLOTS must be at least 2");  end
   if (KEY_W < 1)  begin : g_bad_key    $error("KEY_W must be at least 1");  end
   if (DATA_W < 1) begin : g_bad_data   $error("DATA_W must be at least 1"); end

   rme_pkg::width_e width;
   assign width = wide_sel ? rme_pkg::WIDTH_WIDE : rme_pkg::WIDTH_NARROW;

   logic [SLOTS*KEY_W-1:0] lane_key, lane_mode;
   logic [SLOTS-1:0]       slot_hit, ent_match;
   logic                   c_hit;
   logic [IDX_W-1:0]       c_idx;
   logic [2*DATA_W-1:0]    c_data;

   rme_key_fanout #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_fanout (
      .width(width), .key(key), .mode_mask(mode_mask),
      .lane_key(lane_key), .lane_mode(lane_mode));

   rme_slot_cmp #(.SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_cmp (
      .row(row), .lane_key(lane_key), .lane_mode(lane_mode), .slot_hit(slot_hit));

   rme_entry_merge #(.SLOTS(SLOTS)) u_merge (
      .width(width), .slot_hit(slot_hit), .ent_match(ent_match));

   rme_prio_extract #(.SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_prio (
      .width(width), .row(row), .ent_match(ent_match),
      .hit(c_hit), .idx(c_idx), .data(c_data));

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            match_vec <= '0;
            hit       <= 1'b0;
            idx       <= '0;
            data      <= '0;
         end else begin
            out_valid <= in_valid;
            match_vec <= ent_match;
            hit       <= c_hit;
            idx       <= c_idx;
            data      <= c_data;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign match_vec = ent_match;
      assign hit       = c_hit;
      assign idx       = c_idx;
      assign data      = c_data;
   end
endmodule

// File: rtl/row_match_engine_chk.sv
module row_match_engine_chk #(
   parameter int SLOTS   = 8,
   parameter int KEY_W   = 16,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int IDX_W  = rme_pkg::idx_bits(SLOTS),
   localparam int WIDE_N = SLOTS / 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 wide_sel,
   input logic                 out_valid,
   input logic [SLOTS-1:0]     match_vec,
   input logic                 hit,
   input logic [IDX_W-1:0]     idx,
   input logic [2*DATA_W-1:0]  data
);
   logic [SLOTS-1:0] below_idx;
   assign below_idx = (SLOTS'(1) << idx) - SLOTS'(1);

   a_r4_hit_is_any: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (hit == (match_vec != '0)));

   a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !hit) |-> (idx == '0 && data == '0));

   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && hit) |-> (match_vec[idx] && (match_vec & below_idx) == '0));

   if (REG_OUT) begin : g_seq
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r3_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && wide_sel) |=> ((match_vec >> WIDE_N) == '0));
      a_r6_narrow_data_ext: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !wide_sel) |=> (data[2*DATA_W-1:DATA_W] == '0));
   end else begin : g_comb
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      a_r3_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && wide_sel) |-> ((match_vec >> WIDE_N) == '0));
      a_r6_narrow_data_ext: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !wide_sel) |-> (data[2*DATA_W-1:DATA_W] == '0));
   end
endmodule

bind row_match_engine row_match_engine_chk #(
   .SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
   .out_valid(out_valid), .match_vec(match_vec), .hit(hit), .idx(idx), .data(data)
);

// File: tb/row_match_engine_bench.sv
module row_match_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS  = 8;
   localparam int KEY_W  = 16;
   localparam int DATA_W = 8;
   localparam int SLOT_W = 2*KEY_W + DATA_W;
   localparam int ROW_W  = SLOTS * SLOT_W;
   localparam int IDX_W  = $clog2(SLOTS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic wide_sel = 1'b0;
   logic [ROW_W-1:0]    row = '0;
   logic [2*KEY_W-1:0]  key = '0;
   logic [2*KEY_W-1:0]  mode_mask = '0;
   logic                out_valid, hit;
   logic [SLOTS-1:0]    match_vec;
   logic [IDX_W-1:0]    idx;
   logic [2*DATA_W-1:0] data;

   int checks = 0;
   int failures = 0;

   logic [SLOTS-1:0]    e_mv;
   logic                e_hit, e_valid;
   int                  e_idx;
   logic [2*DATA_W-1:0] e_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   row_match_engine #(.SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_row_match_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
      .row(row), .key(key), .mode_mask(mode_mask), .out_valid(out_valid),
      .match_vec(match_vec), .hit(hit), .idx(idx), .data(data));

   function automatic bit slot_ok(input logic [ROW_W-1:0] r, input int s,
                                  input logic [2*KEY_W-1:0] k, input logic [2*KEY_W-1:0] m,
                                  input int half);
      for (int b = 0; b < KEY_W; b++) begin
         if (!(m[half*KEY_W+b] && r[s*SLOT_W+KEY_W+b]) && (r[s*SLOT_W+b] != k[half*KEY_W+b]))
            return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [DATA_W-1:0] slot_data(input logic [ROW_W-1:0] r, input int s);
      return r[s*SLOT_W + 2*KEY_W +: DATA_W];
   endfunction

   task automatic model();
      e_mv = '0;
      for (int e = 0; e < SLOTS; e++) begin
         if (wide_sel) e_mv[e] = (e < SLOTS/2) && slot_ok(row, 2*e, key, mode_mask, 0)
                                               && slot_ok(row, 2*e+1, key, mode_mask, 1);
         else          e_mv[e] = slot_ok(row, e, key, mode_mask, 0);
      end
      e_hit = 1'b0; e_idx = 0; e_data = '0;
      for (int e = 0; e < SLOTS; e++) begin
         if (e_mv[e] && !e_hit) begin
            e_hit = 1'b1;
            e_idx = e;
            e_data = wide_sel ? {slot_data(row, 2*e+1), slot_data(row, 2*e)}
                              : {{DATA_W{1'b0}}, slot_data(row, e)};
         end
      end
      e_valid = in_valid;
   endtask

   task automatic chk(input bit cond, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(out_valid == e_valid, "R8", "out_valid", out_valid, e_valid);
      if (e_valid) begin
         chk(match_vec == e_mv, wide_sel ? "R3" : "R2", "match_vec (R1 rules)", match_vec, e_mv);
         chk(hit == e_hit, "R4", "hit", hit, e_hit);
         chk(int'(idx) == e_idx, e_hit ? "R5" : "R7", "idx", idx, e_idx);
         chk(data == e_data, e_hit ? "R6" : "R7", "data", data, e_data);
      end
   endtask

   // apply at a falling edge, check the registered result at the next one
   task automatic apply(input logic v, input logic w, input logic [ROW_W-1:0] r,
                        input logic [2*KEY_W-1:0] k, input logic [2*KEY_W-1:0] m);
      in_valid = v; wide_sel = w; row = r; key = k; mode_mask = m;
      model();
      @(negedge clk);
      compare();
   endtask

   function automatic logic [ROW_W-1:0] put_slot(input logic [ROW_W-1:0] r, input int s,
         input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] dc, input logic [DATA_W-1:0] d);
      logic [ROW_W-1:0] t = r;
      t[s*SLOT_W +: SLOT_W] = {d, dc, v};
      return t;
   endfunction

   task automatic random_case(input logic w);
      logic [ROW_W-1:0]   r;
      logic [2*KEY_W-1:0] k, m;
      for (int b = 0; b < ROW_W; b++) r[b] = 1'($urandom_range(0, 1));
      k = 32'($urandom);
      m = 32'($urandom);
      for (int s = 0; s < SLOTS; s++) begin
         if ($urandom_range(0, 2) == 0) begin
            int h = (w && (s % 2 == 1)) ? 1 : 0;
            for (int b = 0; b < KEY_W; b++) begin
               logic dc = 1'($urandom_range(0, 1));
               r[s*SLOT_W+KEY_W+b] = dc;
               if (!(m[h*KEY_W+b] && dc)) r[s*SLOT_W+b] = k[h*KEY_W+b];
            end
         end
      end
      apply(1'b1, w, r, k, m);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [ROW_W-1:0] r;
      logic [KEY_W-1:0] kl, kh;
      kl = 16'h5A3C; kh = 16'hC0DE;

      // R8: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
      chk(hit == 1'b0 && match_vec == '0, "R8", "reset hit/match_vec", match_vec, 0);
      chk(idx == '0 && data == '0, "R8", "reset idx/data", data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: no slot matches
      r = '0;
      for (int s = 0; s < SLOTS; s++) r = put_slot(r, s, ~kl, '0, 8'(s + 1));
      apply(1'b1, 1'b0, r, {kh, kl}, '0);
      chk(hit == 1'b0 && idx == '0 && data == '0, "R7", "miss outputs", data, 0);

      // R1/R5: slot 2 matches via ternary don't-cares, slot 5 exact; slot 2 wins
      r = put_slot(r, 5, kl, '0, 8'h55);
      r = put_slot(r, 2, kl ^ 16'h00F0, 16'h00F0, 8'h22);
      apply(1'b1, 1'b0, r, {kh, kl}, 32'h0000_00F0);
      chk(hit && idx == 3'd2 && data == 16'h0022, "R5", "ternary slot wins", idx, 2);

      // R1: same don't-cares but positions binary -> slot 2 no longer matches
      apply(1'b1, 1'b0, r, {kh, kl}, 32'h0000_0000);
      chk(idx == 3'd5 && data == 16'h0055, "R1", "binary ignores dc bit", idx, 5);

      // R3/R6: wide entry 1 = slots 2,3
      r = '0;
      for (int s = 0; s < SLOTS; s++) r = put_slot(r, s, 16'hFFFF, '0, 8'(s));
      r = put_slot(r, 2, kl, '0, 8'hA1);
      r = put_slot(r, 3, kh, '0, 8'hB2);
      apply(1'b1, 1'b1, r, {kh, kl}, '0);
      chk(hit && idx == 3'd1 && data == 16'hB2A1, "R6", "wide data", data, 16'hB2A1);

      // R3: only low half matches -> miss
      r = put_slot(r, 3, ~kh, '0, 8'hB2);
      apply(1'b1, 1'b1, r, {kh, kl}, '0);
      chk(!hit, "R3", "wide half match", hit, 0);

      // R8: idle cycle
      apply(1'b0, 1'b0, r, {kh, kl}, '0);
      chk(!out_valid, "R8", "idle out_valid", out_valid, 0);

      for (int n = 0; n < 600; n++) random_case(1'b0);
      for (int n = 0; n < 600; n++) random_case(1'b1);
      for (int n = 0; n < 400; n++) random_case(1'($urandom_range(0, 1)));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule